// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32 (64 and 96 are the intended sizes). Software reaches it through a single 32-bit register port. It sets the direction of each pin and drives the output latches. Set and clear operations use write-one semantics, so one pin can be changed without a read-modify-write. The port also reads back the synchronized level of every pin, whatever its direction.

Each pin has its own rising-edge and falling-edge enable. An enabled transition latches a sticky status bit, which software clears by writing a one to it. One interrupt line is raised while any status bit is set. The controller also stores a two-bit alternate-function code per pin, where code 0 means plain GPIO.

The register space is arranged by feature. Each single-bit feature takes NPINS/32 consecutive words, and the alternate-function codes take NPINS/16 words after them. The pins use a tri-state-style interface: an output value, an output enable and a sampled input.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NREG = NPINS/32, the word for feature group g and bank b sits at byte address (g*NREG + b)*4. The group order is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. Pin p is bit p%32 of bank p/32.
- R2: A level read returns each pin's input after a two-flop synchronizer, whatever the pin's direction. The value is readable after the second rising clock edge that follows the change. Writes to the level words have no effect.
- R3: Direction bit 1 makes the pin an output and sets its bit of `pin_oe`. Bit 0 makes the pin an input. Direction words read back as written.
- R4: Writing to a set word drives high the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R5: Writing to a clear word drives low the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R6: A synchronized 0-to-1 change sets the pin's status bit only when its rising enable is 1. A 1-to-0 change sets it only when its falling enable is 1. The two enables are independent and may both be 1. The status bit is visible after the third rising clock edge that follows the input change.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If an enabled edge reaches a status bit in the same cycle that a write-one-to-clear hits that bit, the bit ends up set.
- R9: `irq` is high exactly when at least one status bit is set. It rises only after an enabled edge has been detected.
- R10: The alternate-function code of pin p is two bits wide. It is stored at word p/16 of group 7, bits (p%16)*2+1 down to (p%16)*2. Its words read back as written and do not affect the pins.
- R11: Reads return zero for the set and clear words, for addresses past the last alternate-function word, and for any address whose two low bits are not zero.
- R12: Reset (synchronous, active low) clears direction, output latches, edge enables, status and alternate-function codes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | NPINS | Sampled pin levels |
| pin_out | output | NPINS | Output latch values |
| pin_oe | output | NPINS | Output enables (1 = drive) |
| irq | output | 1 | Combined edge interrupt |

## Verification
In a single cycle, a freshly detected edge and a software write-one-to-clear can both target the same status bit. The bench provokes this by changing a pin on a falling clock edge and counting two rising edges, which is when the detector fires. It then places the clearing write so that it is captured on the very next rising edge. After that edge the status bit must still read as set and `irq` must stay high. A second clear, issued with no new edge pending, must then empty the bit.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants, register group codes and address helper for the
// banked GPIO controller. Assumes 32-bit register words.
package gpio_bank_pkg;

    localparam int WORD_W = 32;
    localparam int AF_W   = 2;

    // Feature groups in address order; the order fixes the register map.
    typedef enum logic [3:0] {
        GRP_LEVEL = 4'd0,
        GRP_DIR   = 4'd1,
        GRP_SET   = 4'd2,
        GRP_CLR   = 4'd3,
        GRP_RISE  = 4'd4,
        GRP_FALL  = 4'd5,
        GRP_STAT  = 4'd6,
        GRP_ALTF  = 4'd7
    } gpio_grp_e;

    // Word index of a given group and bank, with nreg words per group.
    function automatic int grp_word(gpio_grp_e g, int nreg, int bank);
        return int'(g) * nreg + bank;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
// Module: address decoder. It turns a byte address into a one-hot word select
// over NWORDS register words. Assumes word-aligned accesses: an address
// with nonzero low bits, or one past the last word, selects nothing.
module gpio_addr_dec #(
    parameter int NWORDS = 18,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NWORDS-1:0] word_hit
);

    localparam int IDX_W = ADDR_W - 2;

    logic              aligned;
    logic [IDX_W-1:0]  word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    genvar i;
    generate
        for (i = 0; i < NWORDS; i++) begin : g_hit
            // One compare per word of the map.
            assign word_hit[i] = aligned && (word_idx == IDX_W'(i));
        end
    endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the pin inputs. Assumes the pins are
// asynchronous to clk and that one extra cycle of latency is acceptable.
module gpio_in_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the raw pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/gpio_edge_stat.sv
// Module: per-pin edge detector with sticky write-one-to-clear status.
// An edge is the current synchronized level compared with the previous
// cycle's level. A new edge wins over a clear in the same cycle.
// Assumes lvl is already synchronous to clk.
module gpio_edge_stat #(
    parameter int NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status,
    output logic [NPINS-1:0] edge_evt
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] rise_det;
    logic [NPINS-1:0] fall_det;

    // Transition detection against the previous level, qualified by enables.
    always_comb begin
        rise_det = lvl & ~prev_q & rise_en;
        fall_det = ~lvl & prev_q & fall_en;
        edge_evt = rise_det | fall_det;
    end

    // Previous-level history register.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Sticky status: clear by mask, then OR in new edges so they are never lost.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | edge_evt;
    end

    assign status = stat_q;

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the banked GPIO controller. It holds the per-bank direction,
// output latch, edge enable and alternate-function registers, and builds the
// combinational read mux. Assumes NPINS is a multiple of 32 and ADDR_W is
// wide enough for 9*NPINS/32 words. Single-cycle writes, combinational reads.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    localparam int NREG   = NPINS / WORD_W;
    localparam int NAFW   = (NPINS * AF_W) / WORD_W;
    localparam int AF_BASE = int'(GRP_ALTF) * NREG;
    localparam int NWORDS = AF_BASE + NAFW;

    logic [NWORDS-1:0] word_hit;
    logic [NPINS-1:0]  lvl;
    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  out_q;
    logic [NPINS-1:0]  ren_q;
    logic [NPINS-1:0]  fen_q;
    logic [NPINS-1:0]  stat_q;
    logic [NPINS-1:0]  edge_evt;
    logic [NPINS-1:0]  clr_mask;
    logic [WORD_W-1:0] rd_word [NWORDS];

    gpio_addr_dec #(
        .NWORDS (NWORDS),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr     (reg_addr),
        .word_hit (word_hit)
    );

    gpio_in_sync #(
        .W (NPINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    gpio_edge_stat #(
        .NPINS (NPINS)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .rise_en  (ren_q),
        .fall_en  (fen_q),
        .clr_mask (clr_mask),
        .status   (stat_q),
        .edge_evt (edge_evt)
    );

    genvar b;
    generate
        for (b = 0; b < NREG; b++) begin : g_bank
            localparam int I_LVL  = grp_word(GRP_LEVEL, NREG, b);
            localparam int I_DIR  = grp_word(GRP_DIR,   NREG, b);
            localparam int I_SET  = grp_word(GRP_SET,   NREG, b);
            localparam int I_CLR  = grp_word(GRP_CLR,   NREG, b);
            localparam int I_RISE = grp_word(GRP_RISE,  NREG, b);
            localparam int I_FALL = grp_word(GRP_FALL,  NREG, b);
            localparam int I_STAT = grp_word(GRP_STAT,  NREG, b);

            logic [WORD_W-1:0] dir_b;
            logic [WORD_W-1:0] out_b;
            logic [WORD_W-1:0] ren_b;
            logic [WORD_W-1:0] fen_b;
            logic [WORD_W-1:0] set_m;
            logic [WORD_W-1:0] clr_m;

            // Write-one masks for the atomic set and clear words.
            always_comb begin
                set_m = (reg_wr && word_hit[I_SET]) ? reg_wdata : '0;
                clr_m = (reg_wr && word_hit[I_CLR]) ? reg_wdata : '0;
            end

            // Direction register of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)                        dir_b <= '0;
                else if (reg_wr && word_hit[I_DIR]) dir_b <= reg_wdata;
            end

            // Output latch of this bank, updated through the set and clear words.
            always_ff @(posedge clk) begin
                if (!rst_n) out_b <= '0;
                else        out_b <= (out_b | set_m) & ~clr_m;
            end

            // Rising-edge enable register of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)                         ren_b <= '0;
                else if (reg_wr && word_hit[I_RISE]) ren_b <= reg_wdata;
            end

            // Falling-edge enable register of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)                         fen_b <= '0;
                else if (reg_wr && word_hit[I_FALL]) fen_b <= reg_wdata;
            end

            assign dir_q[b*WORD_W +: WORD_W]    = dir_b;
            assign out_q[b*WORD_W +: WORD_W]    = out_b;
            assign ren_q[b*WORD_W +: WORD_W]    = ren_b;
            assign fen_q[b*WORD_W +: WORD_W]    = fen_b;
            assign clr_mask[b*WORD_W +: WORD_W] =
                (reg_wr && word_hit[I_STAT]) ? reg_wdata : '0;

            assign rd_word[I_LVL]  = lvl[b*WORD_W +: WORD_W];
            assign rd_word[I_DIR]  = dir_b;
            assign rd_word[I_SET]  = '0;
            assign rd_word[I_CLR]  = '0;
            assign rd_word[I_RISE] = ren_b;
            assign rd_word[I_FALL] = fen_b;
            assign rd_word[I_STAT] = stat_q[b*WORD_W +: WORD_W];
        end

        for (b = 0; b < NAFW; b++) begin : g_altf
            logic [WORD_W-1:0] af_b;

            // Alternate-function word holding 16 two-bit pin codes.
            always_ff @(posedge clk) begin
                if (!rst_n)                               af_b <= '0;
                else if (reg_wr && word_hit[AF_BASE + b]) af_b <= reg_wdata;
            end

            assign rd_word[AF_BASE + b] = af_b;
        end
    endgenerate

    // Read mux: OR of the selected word; no hit returns zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (word_hit[i]) reg_rdata = reg_rdata | rd_word[i];
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |stat_q;

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
// Module: assertion checker for gpio_bank_ctrl, attached by bind. It watches
// bank 0 register writes at the port and the status and edge signals inside.
module gpio_bank_ctrl_chk #(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  edge_evt
);

    localparam int NREG = NPINS / 32;
    localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(0 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(2 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(3 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6 * NREG * 4);

    // R12
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq && status == '0));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIR) |=> (pin_oe[31:0] == $past(reg_wdata)));

    // R4
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET)
        |=> ((pin_out[31:0] & $past(reg_wdata)) == $past(reg_wdata)
             && (pin_out[31:0] & ~$past(reg_wdata)) == ($past(pin_out[31:0]) & ~$past(reg_wdata))));

    // R5
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR)
        |=> ((pin_out[31:0] & $past(reg_wdata)) == '0
             && (pin_out[31:0] & ~$past(reg_wdata)) == ($past(pin_out[31:0]) & ~$past(reg_wdata))));

    // R2
    level_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_LVL) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R7
    stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata == 32'hFFFF_FFFF && edge_evt[31:0] == '0)
        |=> (status[31:0] == '0));

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |=> ((status & $past(edge_evt)) == $past(edge_evt)));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(edge_evt) != '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .status    (stat_q),
    .edge_evt  (edge_evt)
);

// File: tb/tb_gpio_bank_ctrl.sv
// Directed bench for gpio_bank_ctrl, 64 pins (two words per single-bit group).
module tb_gpio_bank_ctrl;

    localparam int NPINS  = 64;
    localparam int ADDR_W = 8;

    // Byte addresses per R1 with NREG = 2.
    localparam logic [7:0] A_LVL0 = 8'h00, A_LVL1 = 8'h04;
    localparam logic [7:0] A_DIR0 = 8'h08, A_DIR1 = 8'h0C;
    localparam logic [7:0] A_SET0 = 8'h10, A_SET1 = 8'h14;
    localparam logic [7:0] A_CLR0 = 8'h18, A_CLR1 = 8'h1C;
    localparam logic [7:0] A_REN0 = 8'h20, A_REN1 = 8'h24;
    localparam logic [7:0] A_FEN0 = 8'h28, A_FEN1 = 8'h2C;
    localparam logic [7:0] A_ST0  = 8'h30, A_ST1  = 8'h34;
    localparam logic [7:0] A_AF0  = 8'h38, A_AF1  = 8'h3C, A_AF3 = 8'h44;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NPINS-1:0]  pin_in;
    logic [NPINS-1:0]  pin_out;
    logic [NPINS-1:0]  pin_oe;
    logic              irq;
    logic [NPINS-1:0]  ext = '0;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // External pin model: driven pins show the latch, others the outside level.
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_bank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_DIR0, v);  chk("R12", "dir0 after reset", 64'(v), 64'h0);
        rd(A_ST1, v);   chk("R12", "status1 after reset", 64'(v), 64'h0);
        rd(A_AF3, v);   chk("R12", "altf3 after reset", 64'(v), 64'h0);
        chk("R12", "pin_oe/pin_out after reset", pin_oe | pin_out, 64'h0);
        chk("R12", "irq after reset", 64'(irq), 64'h0);
    endtask

    task automatic t_dir_level();
        logic [31:0] v;
        @(negedge clk) ext = 64'hA5A5_0000_1234_5678;
        idle(3);
        rd(A_LVL0, v);  chk("R2", "level0 inputs", 64'(v), 64'h1234_5678);
        rd(A_LVL1, v);  chk("R2", "level1 inputs", 64'(v), 64'hA5A5_0000);
        wr(A_DIR1, 32'h0000_FFFF);
        rd(A_DIR1, v);  chk("R1", "dir1 at 0x0C", 64'(v), 64'h0000_FFFF);
        chk("R3", "pin_oe follows dir", pin_oe, 64'h0000_FFFF_0000_0000);
        wr(A_SET1, 32'h0000_00F0);
        idle(3);
        rd(A_LVL1, v);  chk("R2", "level1 mixed direction", 64'(v), 64'hA5A5_00F0);
        wr(A_LVL0, 32'hFFFF_FFFF);
        chk("R2", "level write ignored (pins)", pin_out, 64'h0000_00F0_0000_0000);
        rd(A_LVL0, v);  chk("R2", "level write ignored (read)", 64'(v), 64'h1234_5678);
        wr(A_CLR1, 32'hFFFF_FFFF);
        wr(A_DIR1, 32'h0);
    endtask

    task automatic t_set_clr();
        logic [31:0] v;
        wr(A_SET0, 32'h0000_00FF);
        chk("R4", "set 0xFF", pin_out, 64'h0000_0000_0000_00FF);
        wr(A_SET0, 32'h0000_0F00);
        chk("R4", "set keeps zeros", pin_out, 64'h0000_0000_0000_0FFF);
        wr(A_CLR0, 32'h0000_000F);
        chk("R5", "clear 0xF", pin_out, 64'h0000_0000_0000_0FF0);
        wr(A_CLR0, 32'h0);
        chk("R5", "clear of zero", pin_out, 64'h0000_0000_0000_0FF0);
        rd(A_SET0, v);  chk("R11", "set reads zero", 64'(v), 64'h0);
        rd(A_CLR0, v);  chk("R11", "clear reads zero", 64'(v), 64'h0);
        wr(A_CLR0, 32'hFFFF_FFFF);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        @(negedge clk) ext = '0;
        idle(4);
        wr(A_REN0, 32'h0000_0028);
        wr(A_FEN0, 32'h0000_0020);
        wr(A_FEN1, 32'h0000_0100);
        rd(A_FEN1, v);  chk("R1", "fall enable bank1 at 0x2C", 64'(v), 64'h100);
        rd(A_REN1, v);  chk("R1", "rise enable bank1 at 0x24", 64'(v), 64'h0);
        @(negedge clk) ext[40] = 1'b1;
        idle(4);
        rd(A_ST1, v);   chk("R6", "rise on fall-only pin", 64'(v), 64'h0);
        @(negedge clk) begin ext[3] = 1'b1; ext[5] = 1'b1; end
        idle(4);
        rd(A_ST0, v);   chk("R6", "rising edges pins 3,5", 64'(v), 64'h28);
        chk("R9", "irq with status", 64'(irq), 64'h1);
        @(negedge clk) ext[40] = 1'b0;
        idle(4);
        rd(A_ST1, v);   chk("R6", "falling edge pin 40", 64'(v), 64'h100);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_ST0, 32'h0000_0008);
        rd(A_ST0, v);   chk("R7", "clear bit 3 only", 64'(v), 64'h20);
        wr(A_ST0, 32'h0);
        rd(A_ST0, v);   chk("R7", "write zero keeps", 64'(v), 64'h20);
        wr(A_ST0, 32'h0000_0020);
        wr(A_ST1, 32'h0000_0100);
        rd(A_ST0, v);   chk("R7", "status0 cleared", 64'(v), 64'h0);
        chk("R9", "irq drops when empty", 64'(irq), 64'h0);
        @(negedge clk) ext[3] = 1'b0;
        idle(4);
        rd(A_ST0, v);   chk("R6", "fall on rise-only pin", 64'(v), 64'h0);
        @(negedge clk) ext[5] = 1'b0;
        idle(4);
        rd(A_ST0, v);   chk("R6", "fall on both-enabled pin", 64'(v), 64'h20);
        wr(A_ST0, 32'hFFFF_FFFF);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk) ext[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = A_ST0; reg_wr = 1'b1; reg_wdata = 32'h0000_0020;
        #1 chk("R6", "status not yet set after 2 edges", 64'(reg_rdata), 64'h0);
        @(negedge clk) reg_wr = 1'b0;
        rd(A_ST0, v);   chk("R8", "edge beats same-cycle clear", 64'(v), 64'h20);
        chk("R9", "irq held after collision", 64'(irq), 64'h1);
        wr(A_ST0, 32'h0000_0020);
        rd(A_ST0, v);   chk("R7", "later clear empties bit", 64'(v), 64'h0);
    endtask

    task automatic t_altf();
        logic [31:0] v;
        wr(A_AF1, 32'h0000_0800);
        rd(A_AF1, v);   chk("R10", "pin 21 code 2", 64'(v), 64'h800);
        wr(A_AF3, 32'hC000_0000);
        rd(A_AF3, v);   chk("R10", "pin 63 code 3", 64'(v), 64'hC000_0000);
        rd(A_AF0, v);   chk("R10", "other word untouched", 64'(v), 64'h0);
        chk("R10", "pins unaffected", pin_out | pin_oe, 64'h0);
        rd(8'h48, v);   chk("R11", "past last word", 64'(v), 64'h0);
        wr(A_DIR0, 32'h1234_5678);
        rd(8'h09, v);   chk("R11", "misaligned read", 64'(v), 64'h0);
        wr(A_DIR0, 32'h0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_dir_level();
        t_set_clr();
        t_edges();
        t_w1c();
        t_collision();
        t_altf();
        finish_run();
    end

endmodule